// File: doc/BRIEF.md
# SPI Serial Clock Divider

This block turns a fast baud-rate reference clock into the serial clock of an SPI master, together with two single-cycle strobes that tell a neighbouring shift engine when the serial clock leaves its idle level (leading edge) and when it returns to it (trailing edge). The division is done in two stages. The first is an optional fixed prescaler that divides by 16. The second is a programmable modulus set by a 4-bit field holding the wanted multiple minus one. With the prescaler bypassed, one serial clock period lasts 4×(m+1) reference cycles. With the prescaler in use it lasts 64×(m+1) reference cycles. The slowest setting is therefore the reference divided by 1024.

The divider, the polarity and the prescaler choice are captured only while the enable input is low. Software clears the enable, rewrites the settings and then raises the enable again. While the block is stopped its counters are cleared and the serial clock rests at the idle level that the polarity input selects. Once enabled, the block always first holds the idle level for one full half period. Only then does it produce the leading edge, so the first pulse is never short.

A three-state machine sequences the output. `ST_STOPPED` is the disabled state. `ST_IDLE_HALF` is a half period at the idle level, and `ST_ACTIVE_HALF` is a half period at the active level. It has five transitions:
- "start": from stopped to idle-half when enable is seen high.
- "lead": from idle-half to active-half when a half period expires, pulsing the leading strobe.
- "trail": from active-half to idle-half when a half period expires, pulsing the trailing strobe.
- "halt": from either running state to stopped when enable is seen low.
- "hold": staying in the current state otherwise.

Top module: `spi_sck_divider`

## Requirements
- R1: While `rst` is high, at the following clock edge `sck` becomes 0, and `lead_stb` and `trail_stb` become 0.
- R2: While `enable` is low, `sck` equals the `cpol` input one clock later, and neither strobe is asserted.
- R3: With `div16` = 0 captured, every half period of `sck` lasts H = 2×(`pm`+1) reference cycles, so a full period is 4×(`pm`+1).
- R4: With `div16` = 1 captured, every half period lasts H = 32×(`pm`+1) reference cycles. This makes the slowest period 1024 reference cycles, at `pm` = 15.
- R5: Call the first rising clock edge that samples `enable` high edge E0. The leading edge of `sck` then appears at edge E0+H, and `sck` holds the idle level for all of the cycles before it.
- R6: `lead_stb` is high for exactly one cycle, in the cycle where `sck` first shows the active level. `trail_stb` is high for exactly one cycle, in the cycle where `sck` first shows the idle level again. The two strobes alternate and are never high together.
- R7: The idle level of `sck` is `cpol` (0 = idle low, 1 = idle high). The active level is its inverse.
- R8: Changes to `cpol`, `div16` or `pm` while `enable` is high have no effect on `sck` or on the strobes until the next time `enable` goes low.
- R9: Once an edge samples `enable` low, `sck` returns to the idle level after that edge, with no strobe, even in the middle of an active half. A later enable restarts at R5 timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Baud-rate reference clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Runs the divider; settings are captured while low |
| cpol | input | 1 | Idle level of the serial clock |
| div16 | input | 1 | Selects the extra divide-by-16 prescaler |
| pm | input | 4 | Modulus minus one (multiples 1 to 16) |
| sck | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle pulse with each leading edge of sck |
| trail_stb | output | 1 | One-cycle pulse with each trailing edge of sck |

## Verification
The assertions assume two things: inputs are stable around the rising edge of the reference clock, and reset is held long enough to clear every register before any property is judged. They also take for granted that the settings change only through the enable-low window, although the design itself tolerates edits at any time. The stimulus drives every input on the falling edge and picks random settings from a fixed seed. It deliberately disturbs the settings in the middle of a running clock, so that the freeze of R8 is exercised inside the assumptions and not against them.

// File: rtl/spi_sck_divider_pkg.sv
package spi_sck_divider_pkg;

    typedef enum logic [1:0] {
        ST_STOPPED     = 2'd0,
        ST_IDLE_HALF   = 2'd1,
        ST_ACTIVE_HALF = 2'd2
    } sck_state_e;

    typedef struct packed {
        logic       cpol;
        logic       div16;
        logic [3:0] pm;
    } sck_cfg_t;

endpackage

// File: rtl/sckdiv_cfg_hold.sv
module sckdiv_cfg_hold
    import spi_sck_divider_pkg::*;
(
    input  logic     clk_ref,
    input  logic     rst,
    input  logic     running,
    input  sck_cfg_t cfg_in,
    output sck_cfg_t cfg_q
);

    // Settings follow the inputs only while the divider is stopped.
    always_ff @(posedge clk_ref) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (!running) begin
            cfg_q <= cfg_in;
        end
    end

    // R8: captured settings stay frozen across consecutive running cycles
    a_r8_cfg_frozen: assert property (@(posedge clk_ref) disable iff (rst)
        (running && $past(running)) |-> $stable(cfg_q));

endmodule

// File: rtl/sckdiv_prescale.sv
module sckdiv_prescale #(
    parameter int PRE_RATIO = 16
) (
    input  logic clk_ref,
    input  logic rst,
    input  logic running,
    input  logic use_pre,
    output logic tick
);

    localparam int PRE_W = $clog2(PRE_RATIO);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_RATIO - 1);

    logic [PRE_W-1:0] pre_cnt;

    always_comb begin
        if (!running) begin
            tick = 1'b0;
        end else if (!use_pre) begin
            tick = 1'b1;
        end else begin
            tick = (pre_cnt == PRE_LAST);
        end
    end

    always_ff @(posedge clk_ref) begin
        if (rst || !running || !use_pre) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + PRE_W'(1);
        end
    end

    // R4: the prescaler only advances when the divide-by-16 stage is chosen
    a_r4_pre_idle: assert property (@(posedge clk_ref) disable iff (rst)
        !use_pre |=> (pre_cnt == '0));

endmodule

// File: rtl/sckdiv_half_counter.sv
module sckdiv_half_counter #(
    parameter int PM_W      = 4,
    parameter int BASE_HALF = 2
) (
    input  logic            clk_ref,
    input  logic            rst,
    input  logic            running,
    input  logic            tick,
    input  logic [PM_W-1:0] pm,
    output logic            half_done
);

    localparam int HALF_MAX = BASE_HALF << PM_W;
    localparam int HC_W     = $clog2(HALF_MAX);

    logic [HC_W-1:0] half_cnt;
    logic [HC_W:0]   span;
    logic [HC_W-1:0] half_last;

    always_comb begin
        span      = (HC_W+1)'(BASE_HALF) * ((HC_W+1)'(pm) + (HC_W+1)'(1));
        half_last = HC_W'(span - (HC_W+1)'(1));
        half_done = running && tick && (half_cnt == half_last);
    end

    always_ff @(posedge clk_ref) begin
        if (rst || !running) begin
            half_cnt <= '0;
        end else if (half_done) begin
            half_cnt <= '0;
        end else if (tick) begin
            half_cnt <= half_cnt + HC_W'(1);
        end
    end

    // R3: the half-period count never passes the modulus limit
    a_r3_count_bound: assert property (@(posedge clk_ref) disable iff (rst)
        running |-> (half_cnt <= half_last));

endmodule

// File: rtl/spi_sck_divider.sv
module spi_sck_divider
    import spi_sck_divider_pkg::*;
#(
    parameter int PM_W      = 4,
    parameter int PRE_RATIO = 16,
    parameter int BASE_HALF = 2
) (
    input  logic            clk_ref,
    input  logic            rst,
    input  logic            enable,
    input  logic            cpol,
    input  logic            div16,
    input  logic [PM_W-1:0] pm,
    output logic            sck,
    output logic            lead_stb,
    output logic            trail_stb
);

    sck_state_e state_q, state_d;
    sck_cfg_t   cfg_in, cfg_q;
    logic       running;
    logic       tick;
    logic       half_done;

    assign running = (state_q != ST_STOPPED);

    always_comb begin
        cfg_in       = '0;
        cfg_in.cpol  = cpol;
        cfg_in.div16 = div16;
        cfg_in.pm    = 4'(pm);
    end

    sckdiv_cfg_hold u_cfg (
        .clk_ref (clk_ref),
        .rst     (rst),
        .running (running),
        .cfg_in  (cfg_in),
        .cfg_q   (cfg_q)
    );

    sckdiv_prescale #(
        .PRE_RATIO (PRE_RATIO)
    ) u_pre (
        .clk_ref (clk_ref),
        .rst     (rst),
        .running (running),
        .use_pre (cfg_q.div16),
        .tick    (tick)
    );

    sckdiv_half_counter #(
        .PM_W      (PM_W),
        .BASE_HALF (BASE_HALF)
    ) u_half (
        .clk_ref   (clk_ref),
        .rst       (rst),
        .running   (running),
        .tick      (tick),
        .pm        (PM_W'(cfg_q.pm)),
        .half_done (half_done)
    );

    // Next-state logic: start, lead, trail, halt, hold.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED: begin
                if (enable) state_d = ST_IDLE_HALF;
            end
            ST_IDLE_HALF: begin
                if (!enable)        state_d = ST_STOPPED;
                else if (half_done) state_d = ST_ACTIVE_HALF;
            end
            ST_ACTIVE_HALF: begin
                if (!enable)        state_d = ST_STOPPED;
                else if (half_done) state_d = ST_IDLE_HALF;
            end
            default: state_d = ST_STOPPED;
        endcase
    end

    // State register.
    always_ff @(posedge clk_ref) begin
        if (rst) begin
            state_q <= ST_STOPPED;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: level and strobes for the coming state.
    always_ff @(posedge clk_ref) begin
        if (rst) begin
            sck       <= 1'b0;
            lead_stb  <= 1'b0;
            trail_stb <= 1'b0;
        end else begin
            lead_stb  <= 1'b0;
            trail_stb <= 1'b0;
            unique case (state_d)
                ST_STOPPED: begin
                    sck <= (state_q == ST_STOPPED) ? cpol : cfg_q.cpol;
                end
                ST_IDLE_HALF: begin
                    if (state_q == ST_STOPPED) begin
                        sck <= cpol;
                    end else begin
                        sck <= cfg_q.cpol;
                        trail_stb <= (state_q == ST_ACTIVE_HALF);
                    end
                end
                ST_ACTIVE_HALF: begin
                    sck      <= ~cfg_q.cpol;
                    lead_stb <= (state_q == ST_IDLE_HALF);
                end
                default: sck <= cfg_q.cpol;
            endcase
        end
    end

    // R6: strobes never overlap
    a_r6_strobe_excl: assert property (@(posedge clk_ref) disable iff (rst)
        $onehot0({lead_stb, trail_stb}));

    // R6: a leading strobe marks a change of sck to the active level
    a_r6_lead_edge: assert property (@(posedge clk_ref) disable iff (rst)
        lead_stb |-> (sck != $past(sck)) && (sck != cfg_q.cpol));

    // R6: a trailing strobe marks a return of sck to the idle level
    a_r6_trail_edge: assert property (@(posedge clk_ref) disable iff (rst)
        trail_stb |-> (sck != $past(sck)) && (sck == cfg_q.cpol));

    // R2: a stopped divider emits no strobes
    a_r2_quiet_stopped: assert property (@(posedge clk_ref) disable iff (rst)
        (state_q == ST_STOPPED) |-> !lead_stb && !trail_stb);

    // R9: sck rests at the captured idle level right after a halt
    a_r9_halt_idle: assert property (@(posedge clk_ref) disable iff (rst)
        (running && !enable) |=> (sck == $past(cfg_q.cpol)) && !lead_stb && !trail_stb);

endmodule

// File: tb/spi_sck_divider_test.sv
`timescale 1ns/1ps
module spi_sck_divider_test;

    logic       clk_ref = 1'b0;
    logic       rst;
    logic       enable;
    logic       cpol;
    logic       div16;
    logic [3:0] pm;
    logic       sck;
    logic       lead_stb;
    logic       trail_stb;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk_ref = ~clk_ref;

    spi_sck_divider uut (
        .clk_ref   (clk_ref),
        .rst       (rst),
        .enable    (enable),
        .cpol      (cpol),
        .div16     (div16),
        .pm        (pm),
        .sck       (sck),
        .lead_stb  (lead_stb),
        .trail_stb (trail_stb)
    );

    function automatic int half_len(bit d, int p);
        return (d ? 32 : 2) * (p + 1);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Runs one configuration, ends inside an active half, then halts.
    task automatic run_cfg(bit d, int p, bit c, int periods, bit disturb);
        int h, total;
        int bad_sck, bad_lead, bad_trail;
        int a_sck, e_sck, a_l, e_l, a_t, e_t;
        bit first_seen;
        int first_at;
        enable = 1'b0;
        div16  = d;
        pm     = 4'(p);
        cpol   = c;
        repeat (3) @(negedge clk_ref);
        // R2: idle level follows cpol, no strobes while stopped
        check(sck == c, "R2 idle level", int'(sck), int'(c));
        check(!lead_stb && !trail_stb, "R2 strobes quiet", int'({lead_stb, trail_stb}), 0);
        h = half_len(d, p);
        total = 2 * h * periods + h + h / 2;
        bad_sck = 0; bad_lead = 0; bad_trail = 0;
        a_sck = 0; e_sck = 0; a_l = 0; e_l = 0; a_t = 0; e_t = 0;
        first_seen = 1'b0; first_at = 0;
        enable = 1'b1;
        for (int cyc = 1; cyc <= total; cyc++) begin
            int q, r;
            bit xs, xl, xt;
            @(negedge clk_ref);
            if (disturb && cyc == 3) begin
                // R8: edits while running must be ignored
                div16 = ~d;
                pm    = 4'(p ^ 5);
                cpol  = ~c;
            end
            q  = (cyc - 1) / h;
            r  = (cyc - 1) % h;
            xs = c ^ q[0];
            xl = (r == 0) && q[0];
            xt = (r == 0) && (q >= 2) && !q[0];
            if (lead_stb && !first_seen) begin
                first_seen = 1'b1;
                first_at   = cyc;
            end
            if (sck != xs && bad_sck == 0) begin a_sck = int'(sck); e_sck = int'(xs); end
            if (sck != xs) bad_sck++;
            if (lead_stb != xl && bad_lead == 0) begin a_l = cyc; e_l = int'(xl); end
            if (lead_stb != xl) bad_lead++;
            if (trail_stb != xt && bad_trail == 0) begin a_t = cyc; e_t = int'(xt); end
            if (trail_stb != xt) bad_trail++;
        end
        // R5: first leading edge after one full idle half
        check(first_at == h + 1, "R5 first lead cycle", first_at, h + 1);
        // R3 or R4 with R7: sck level over every half, by polarity
        if (d) check(bad_sck == 0, "R4 R7 sck waveform", a_sck, e_sck);
        else   check(bad_sck == 0, "R3 R7 sck waveform", a_sck, e_sck);
        // R6: strobe placement (actual = first bad cycle)
        check(bad_lead == 0, "R6 lead strobe", a_l, e_l);
        check(bad_trail == 0, "R6 trail strobe", a_t, e_t);
        if (disturb) check(bad_sck + bad_lead + bad_trail == 0, "R8 frozen config",
                           bad_sck + bad_lead + bad_trail, 0);
        // R9: halt inside an active half returns sck to idle at once
        cpol   = c;
        enable = 1'b0;
        @(negedge clk_ref);
        check(sck == c, "R9 halt idle level", int'(sck), int'(c));
        check(!lead_stb && !trail_stb, "R9 halt no strobe", int'({lead_stb, trail_stb}), 0);
    endtask

    initial begin
        int seed;
        seed   = 1234;
        void'($urandom(seed));
        rst    = 1'b1;
        enable = 1'b0;
        cpol   = 1'b1;
        div16  = 1'b0;
        pm     = 4'd0;
        repeat (3) @(negedge clk_ref);
        // R1: reset state
        check(sck == 1'b0, "R1 reset sck", int'(sck), 0);
        check(!lead_stb && !trail_stb, "R1 reset strobes", int'({lead_stb, trail_stb}), 0);
        rst = 1'b0;
        // directed corners
        run_cfg(1'b0, 0, 1'b0, 3, 1'b0);   // fastest, R3
        run_cfg(1'b0, 0, 1'b1, 3, 1'b0);   // inverted polarity, R7
        run_cfg(1'b0, 15, 1'b1, 2, 1'b0);  // largest modulus, R3
        run_cfg(1'b1, 0, 1'b0, 2, 1'b0);   // prescaler alone, R4
        run_cfg(1'b1, 15, 1'b0, 1, 1'b0);  // slowest 1024 ratio, R4
        run_cfg(1'b0, 3, 1'b0, 3, 1'b1);   // disturbed while running, R8
        run_cfg(1'b1, 2, 1'b1, 2, 1'b1);   // disturbed with prescaler, R8
        // random settings
        for (int k = 0; k < 8; k++) begin
            bit rd, rc, rx;
            int rp;
            rd = 1'($urandom % 2);
            rc = 1'($urandom % 2);
            rx = 1'($urandom % 2);
            rp = int'($urandom % 16);
            run_cfg(rd, rp, rc, 2, rx);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk_ref);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule